// File: doc/BRIEF.md
# Authentication Command Front-End Sequencer

This block sits behind a serial bus front end that has already turned bus traffic into whole bytes. It is the byte-level controller for a "compute hash" request made to a secure memory. The master sends a command byte, a two-byte target address that points anywhere inside the wanted memory page, and a control byte that names the hash function. The sequencer then returns an inverted CRC-16 over those four bytes. If the request is sound, it starts an external hash engine through a start/done handshake that carries the function, the page index and the secret number.

While the engine is working, every byte the master reads is all ones. Once the engine reports done, the read pattern turns to alternating bits. The sequencer re-arms only after the master has clocked out one full byte (8 bits) of that pattern. A malformed request never starts the engine, and it leaves the block returning all ones until a bus reset pulse arrives. When the engine finishes, the block also produces the updated device status flags for the function that ran, as a one-cycle write to the flag store.

Top module: `auth_cmd_seq`

## Requirements
- R1: In the ready state, a received byte other than the command code (default 8'h33) is refused: `ready` drops, reads return 8'hFF, no engine start follows, and only `bus_rst` brings the block back to ready.
- R2: After the command byte, the next two bytes form the target address, low byte first. `eng_secret` equals address bits [7:6], and `eng_page` equals address bits [8:5] (32-byte pages, 16 pages).
- R3: After the control byte, the two read bytes are the bitwise inverse of a CRC-16 (polynomial x^16+x^15+x^2+1, reflected, initial value zero, bits taken LSB first) over the command, address-low, address-high and control bytes. The low CRC byte is read first.
- R4: A request is valid only if the control byte is 8'h0F, 8'hF0 or 8'h3C and the address is below 512.
- R5: On a valid request, `eng_start` is high for exactly one cycle, in the cycle after the second CRC byte is read. `eng_func` is then 0 for 8'h0F (first secret), 1 for 8'hF0 (next secret) and 2 for 8'h3C (validate page).
- R6: From the engine start until `eng_done`, `rd_data` is 8'hFF. From the cycle after `eng_done` it is 8'hAA, i.e. 0,1,0,1,... when sent LSB first.
- R7: On an invalid request, `eng_start` stays low, reads stay 8'hFF and `ready` stays low until `bus_rst`. In the cycle after `bus_rst` is sampled, `ready` is high.
- R8: While the engine is busy or the alternating pattern has not been read, `bus_rst` has no effect. `ready` returns only in the cycle after one read of the 8'hAA byte.
- R9: Flag layout is [10] hide, [9] challenge, [8] auth, [7] match, [6] m, [5] x, [4:0] ending offset. For both secret functions, `flags_we` pulses in the cycle after `eng_done`, with hide set, bits [9:5] cleared and the offset set to 5'h1F.
- R10: For validate page, `flags_we` pulses in the cycle after `eng_done`, with `new_flags` equal to `cur_flags` except that bit [6] takes the value of bit [7].
- R11: `rst_n` low returns the block to ready at once from any state and abandons a pending computation. A later `eng_done` then writes no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rst | input | 1 | Bus reset pulse from the front end |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | The master has taken the byte on `rd_data` |
| rd_data | output | 8 | Byte offered to the master |
| ready | output | 1 | Idle and able to accept a new command |
| eng_start | output | 1 | One-cycle start to the hash engine |
| eng_func | output | 2 | Function select for the engine |
| eng_secret | output | 2 | Secret number for the selected page |
| eng_page | output | PAGE_IDX_W | Selected page index |
| eng_done | input | 1 | Engine completion pulse |
| cur_flags | input | 11 | Present device status flags |
| flags_we | output | 1 | Write strobe for updated flags |
| new_flags | output | 11 | Updated flags |

## Verification
Randomly drawn requests mix the three valid control codes with arbitrary control bytes and with addresses inside and beyond the 512-byte space. This separates the validity check from the function mapping and from the address-to-page and secret split. Occasional wrong command bytes exercise the refusal path. Random flag inputs with random busy lengths show whether each function applies its own flag update and whether the pattern switches exactly at done. Directed cases cover a bus reset while busy and while the alternating byte is pending, and an asynchronous reset in mid-computation followed by a stale done pulse.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

  localparam int FLG_W   = 11;
  localparam int FB_HIDE = 10;
  localparam int FB_CHLG = 9;
  localparam int FB_AUTH = 8;
  localparam int FB_MTCH = 7;
  localparam int FB_M    = 6;
  localparam int FB_X    = 5;
  localparam int OFS_W   = 5;

  localparam logic [7:0] CTL_FIRST = 8'h0F;
  localparam logic [7:0] CTL_NEXT  = 8'hF0;
  localparam logic [7:0] CTL_VALID = 8'h3C;

  localparam logic [7:0] PAT_BUSY  = 8'hFF;
  localparam logic [7:0] PAT_DONE  = 8'hAA;

  typedef enum logic [1:0] {
    FN_FIRST_SECRET = 2'd0,
    FN_NEXT_SECRET  = 2'd1,
    FN_VALIDATE     = 2'd2,
    FN_NONE         = 2'd3
  } fn_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR_LO, ST_ADDR_HI, ST_CTL,
    ST_CRC_LO, ST_CRC_HI, ST_BUSY, ST_DONE, ST_LOCK
  } st_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/auth_crc_acc.sv
module auth_crc_acc
  import auth_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] base, crc_n;

  always_comb begin
    base  = clr ? 16'h0000 : crc;
    crc_n = en ? crc16_step(base, din) : base;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) crc <= 16'h0000;
    else         crc <= crc_n;
  end
endmodule

// File: rtl/auth_req_decode.sv
module auth_req_decode
  import auth_seq_pkg::*;
#(
  parameter int PAGE_IDX_W      = 4,
  parameter int PAGE_BYTES_LOG2 = 5
) (
  input  logic [7:0]  ctl,
  input  logic [15:0] addr,
  output logic        ok,
  output fn_e         func
);
  localparam int SPACE_BITS = PAGE_IDX_W + PAGE_BYTES_LOG2;

  logic addr_ok;

  always_comb begin
    addr_ok = ((addr >> SPACE_BITS) == 16'd0);
    unique case (ctl)
      CTL_FIRST: func = FN_FIRST_SECRET;
      CTL_NEXT:  func = FN_NEXT_SECRET;
      CTL_VALID: func = FN_VALIDATE;
      default:   func = FN_NONE;
    endcase
    ok = addr_ok && (func != FN_NONE);
  end
endmodule

// File: rtl/auth_flag_update.sv
module auth_flag_update
  import auth_seq_pkg::*;
(
  input  logic [FLG_W-1:0] cur,
  input  fn_e              func,
  output logic [FLG_W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (func == FN_FIRST_SECRET || func == FN_NEXT_SECRET) begin
      nxt[FB_HIDE]     = 1'b1;
      nxt[FB_CHLG]     = 1'b0;
      nxt[FB_AUTH]     = 1'b0;
      nxt[FB_MTCH]     = 1'b0;
      nxt[FB_M]        = 1'b0;
      nxt[FB_X]        = 1'b0;
      nxt[OFS_W-1:0]   = '1;
    end else if (func == FN_VALIDATE) begin
      nxt[FB_M]        = cur[FB_MTCH];
    end
  end
endmodule

// File: rtl/auth_cmd_seq.sv
module auth_cmd_seq
  import auth_seq_pkg::*;
#(
  parameter int         PAGE_IDX_W      = 4,
  parameter int         PAGE_BYTES_LOG2 = 5,
  parameter logic [7:0] CMD_CODE        = 8'h33
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rst,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  rd_req,
  output logic [7:0]            rd_data,
  output logic                  ready,
  output logic                  eng_start,
  output logic [1:0]            eng_func,
  output logic [1:0]            eng_secret,
  output logic [PAGE_IDX_W-1:0] eng_page,
  input  logic                  eng_done,
  input  logic [FLG_W-1:0]      cur_flags,
  output logic                  flags_we,
  output logic [FLG_W-1:0]      new_flags
);
  localparam int SEC_LSB = 6;

  logic [1:0]       rst_sync;
  logic             rst_ni;
  st_e              st_q, st_n;
  logic [15:0]      addr_q;
  logic [7:0]       ctl_q;
  fn_e              func_q, dec_func;
  logic             start_q, start_n;
  logic             we_q, we_n;
  logic [FLG_W-1:0] flags_q, flags_upd;
  logic [15:0]      crc;
  logic             req_ok, crc_clr, crc_en, in_rx, brk_ok;
  logic             lo_en, hi_en, ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  auth_crc_acc u_crc (
    .clk(clk), .rst_ni(rst_ni), .clr(crc_clr), .en(crc_en),
    .din(rx_byte), .crc(crc)
  );

  auth_req_decode #(.PAGE_IDX_W(PAGE_IDX_W), .PAGE_BYTES_LOG2(PAGE_BYTES_LOG2)) u_dec (
    .ctl(ctl_q), .addr(addr_q), .ok(req_ok), .func(dec_func)
  );

  auth_flag_update u_flg (.cur(cur_flags), .func(func_q), .nxt(flags_upd));

  always_comb begin
    in_rx   = (st_q == ST_IDLE) || (st_q == ST_ADDR_LO) ||
              (st_q == ST_ADDR_HI) || (st_q == ST_CTL);
    brk_ok  = (st_q != ST_BUSY) && (st_q != ST_DONE);
    crc_clr = (st_q == ST_IDLE);
    crc_en  = in_rx && rx_valid && !bus_rst;
    lo_en   = (st_q == ST_ADDR_LO) && rx_valid && !bus_rst;
    hi_en   = (st_q == ST_ADDR_HI) && rx_valid && !bus_rst;
    ctl_en  = (st_q == ST_CTL)     && rx_valid && !bus_rst;
  end

  always_comb begin
    st_n    = st_q;
    start_n = 1'b0;
    we_n    = 1'b0;
    if (bus_rst && brk_ok) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (rx_valid) st_n = (rx_byte == CMD_CODE) ? ST_ADDR_LO : ST_LOCK;
        ST_ADDR_LO: if (rx_valid) st_n = ST_ADDR_HI;
        ST_ADDR_HI: if (rx_valid) st_n = ST_CTL;
        ST_CTL:     if (rx_valid) st_n = ST_CRC_LO;
        ST_CRC_LO:  if (rd_req)   st_n = ST_CRC_HI;
        ST_CRC_HI:  if (rd_req) begin
                      st_n    = req_ok ? ST_BUSY : ST_LOCK;
                      start_n = req_ok;
                    end
        ST_BUSY:    if (eng_done) begin
                      st_n = ST_DONE;
                      we_n = 1'b1;
                    end
        ST_DONE:    if (rd_req)   st_n = ST_IDLE;
        ST_LOCK:    st_n = ST_LOCK;
        default:    st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= 16'h0000;
      ctl_q   <= 8'h00;
      func_q  <= FN_NONE;
      start_q <= 1'b0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      st_q    <= st_n;
      start_q <= start_n;
      we_q    <= we_n;
      if (lo_en)   addr_q[7:0]  <= rx_byte;
      if (hi_en)   addr_q[15:8] <= rx_byte;
      if (ctl_en)  ctl_q        <= rx_byte;
      if (start_n) func_q       <= dec_func;
      if (we_n)    flags_q      <= flags_upd;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_CRC_LO: rd_data = ~crc[7:0];
      ST_CRC_HI: rd_data = ~crc[15:8];
      ST_DONE:   rd_data = PAT_DONE;
      default:   rd_data = PAT_BUSY;
    endcase
  end

  assign ready      = (st_q == ST_IDLE);
  assign eng_start  = start_q;
  assign eng_func   = func_q;
  assign eng_secret = addr_q[SEC_LSB +: 2];
  assign eng_page   = addr_q[PAGE_BYTES_LOG2 +: PAGE_IDX_W];
  assign flags_we   = we_q;
  assign new_flags  = flags_q;
endmodule

// File: rtl/auth_cmd_seq_chk.sv
module auth_cmd_seq_chk
  import auth_seq_pkg::*;
#(
  parameter int PAGE_IDX_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_rst,
  input logic                  rd_req,
  input logic [7:0]            rd_data,
  input logic                  ready,
  input logic                  eng_start,
  input logic [1:0]            eng_func,
  input logic                  eng_done,
  input logic                  flags_we,
  input logic [FLG_W-1:0]      new_flags
);
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_start) |-> $past(rd_req));

  p_busy_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (rd_data == PAT_BUSY) && !ready);

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$past(ready)) |-> $past(bus_rst || (rd_req && rd_data == PAT_DONE)));

  p_secret_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && eng_func != 2'd2) |->
      (new_flags[FB_HIDE] && new_flags[FB_CHLG:FB_X] == 5'd0 && new_flags[OFS_W-1:0] == 5'h1F));

  p_flags_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> $past(eng_done) && !$past(flags_we));
endmodule

bind auth_cmd_seq auth_cmd_seq_chk #(.PAGE_IDX_W(PAGE_IDX_W)) u_chk (.*);

// File: tb/auth_cmd_seq_bench.sv
module auth_cmd_seq_bench;
  logic        clk, rst_n, bus_rst, rx_valid, rd_req, eng_done;
  logic [7:0]  rx_byte, rd_data;
  logic        ready, eng_start, flags_we;
  logic [1:0]  eng_func, eng_secret;
  logic [3:0]  eng_page;
  logic [10:0] cur_flags, new_flags;

  int n_chk, n_bad, cyc;
  bit done_run;

  auth_cmd_seq u_auth_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_req(rd_req), .rd_data(rd_data), .ready(ready),
    .eng_start(eng_start), .eng_func(eng_func), .eng_secret(eng_secret),
    .eng_page(eng_page), .eng_done(eng_done), .cur_flags(cur_flags),
    .flags_we(flags_we), .new_flags(new_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done_run) begin
      n_bad++;
      $display("FAIL watchdog (all R): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] bytes4);
    logic [15:0] c;
    logic fb;
    c = 16'h0;
    for (int k = 0; k < 32; k++) begin
      fb = c[0] ^ bytes4[k];
      c  = {1'b0, c[15:1]};
      if (fb) begin
        c[15] = ~c[15]; c[13] = ~c[13]; c[0] = ~c[0];
      end
    end
    return c;
  endfunction

  function automatic logic [10:0] ref_flags(input logic [10:0] f, input logic [7:0] ctl);
    logic [10:0] r;
    r = f;
    if (ctl == 8'h0F || ctl == 8'hF0) r = {1'b1, 5'b00000, 5'b11111};
    else if (ctl == 8'h3C) r[6] = f[7];
    return r;
  endfunction

  function automatic logic [1:0] ref_func(input logic [7:0] ctl);
    return (ctl == 8'h0F) ? 2'd0 : (ctl == 8'hF0) ? 2'd1 : 2'd2;
  endfunction

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd_pulse();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic brst_pulse();
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input logic [15:0] addr,
                         input logic [7:0] ctl, input logic [10:0] cf, input int busy_n);
    logic [15:0] c;
    bit ok;
    cur_flags = cf;
    ok = (ctl == 8'h0F || ctl == 8'hF0 || ctl == 8'h3C) && (addr < 16'd512);
    send(cmd);
    if (cmd != 8'h33) begin
      send(8'h12);
      chk(!ready && rd_data == 8'hFF, "R1 refused command", {rd_data, 7'b0, ready}, 32'hFF00);
      rd_pulse(); rd_pulse();
      chk(!eng_start && !ready, "R1 no start after refusal", {eng_start, ready}, 0);
      brst_pulse();
      chk(ready == 1'b1, "R7 bus reset rearms", ready, 1);
      return;
    end
    send(addr[7:0]); send(addr[15:8]); send(ctl);
    c = ref_crc({ctl, addr[15:8], addr[7:0], cmd});
    chk(rd_data == ~c[7:0], "R3 crc low byte", rd_data, ~c[7:0]);
    rd_pulse();
    chk(rd_data == ~c[15:8], "R3 crc high byte", rd_data, ~c[15:8]);
    rd_pulse();
    if (!ok) begin
      for (int i = 0; i < 3; i++) begin
        chk(!eng_start && rd_data == 8'hFF && !ready, "R7 R4 invalid request holds",
            {eng_start, rd_data, ready}, {1'b0, 8'hFF, 1'b0});
        rd_pulse();
      end
      brst_pulse();
      chk(ready == 1'b1, "R7 bus reset after invalid", ready, 1);
      return;
    end
    chk(eng_start == 1'b1, "R5 R4 start pulse", eng_start, 1);
    chk(eng_func == ref_func(ctl), "R5 function select", eng_func, ref_func(ctl));
    chk(eng_secret == addr[7:6] && eng_page == addr[8:5], "R2 secret and page",
        {eng_secret, eng_page}, {addr[7:6], addr[8:5]});
    for (int i = 0; i < busy_n; i++) begin
      chk(rd_data == 8'hFF && !ready, "R6 busy pattern", rd_data, 8'hFF);
      if (i == 0) rd_pulse(); else @(negedge clk);
      chk(eng_start == 1'b0, "R5 start single cycle", eng_start, 0);
    end
    brst_pulse();
    chk(!ready && rd_data == 8'hFF, "R8 bus reset ignored while busy", {ready, rd_data}, 8'hFF);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(flags_we == 1'b1, "R9 R10 flag strobe", flags_we, 1);
    chk(new_flags == ref_flags(cf, ctl), (ctl == 8'h3C) ? "R10 validate flags" : "R9 secret flags",
        new_flags, ref_flags(cf, ctl));
    chk(rd_data == 8'hAA, "R6 done pattern", rd_data, 8'hAA);
    brst_pulse();
    chk(flags_we == 1'b0, "R9 strobe single cycle", flags_we, 0);
    chk(!ready && rd_data == 8'hAA, "R8 bus reset ignored before pattern read",
        {ready, rd_data}, 8'hAA);
    rd_pulse();
    chk(ready == 1'b1, "R8 rearm after pattern byte", ready, 1);
  endtask

  initial begin
    logic [7:0]  ctl, cmd;
    logic [15:0] addr;
    int r;
    n_chk = 0; n_bad = 0; cyc = 0; done_run = 0;
    rst_n = 1'b0; bus_rst = 0; rx_valid = 0; rx_byte = 0; rd_req = 0;
    eng_done = 0; cur_flags = 0;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready && !eng_start && !flags_we && rd_data == 8'hFF, "R11 reset state",
        {ready, eng_start, flags_we, rd_data}, {3'b100, 8'hFF});

    run_cmd(8'h33, 16'h01C5, 8'h0F, 11'h0C3, 2);
    run_cmd(8'h33, 16'h01FF, 8'hF0, 11'h2A5, 1);
    run_cmd(8'h33, 16'h0040, 8'h3C, 11'h080, 3);
    run_cmd(8'h33, 16'h0040, 8'h3C, 11'h040, 1);
    run_cmd(8'h33, 16'h0200, 8'h0F, 11'h000, 1);
    run_cmd(8'h33, 16'h0010, 8'h55, 11'h000, 1);
    run_cmd(8'hCC, 16'h0010, 8'h0F, 11'h000, 1);

    send(8'h33); send(8'h20); send(8'h00); send(8'hF0);
    rd_pulse(); rd_pulse();
    chk(eng_start == 1'b1, "R5 start before async reset", eng_start, 1);
    #2 rst_n = 1'b0;
    #1 chk(ready && rd_data == 8'hFF, "R11 async reset to ready", {ready, rd_data}, {1'b1, 8'hFF});
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk(!flags_we && ready, "R11 stale done ignored", {flags_we, ready}, 2'b01);

    for (int n = 0; n < 40; n++) begin
      r = $urandom % 5;
      ctl  = (r == 0) ? 8'h0F : (r == 1) ? 8'hF0 : (r == 3) ? 8'($urandom) : 8'h3C;
      addr = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 512);
      cmd  = ($urandom % 10 == 0) ? 8'h34 : 8'h33;
      run_cmd(cmd, addr, ctl, 11'($urandom), 1 + int'($urandom % 6));
    end

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule